// File: doc/BRIEF.md
# Supply Monitor Write-Protect Sequencer

This block watches a stream of supply-voltage samples, given in millivolts by an external converter, and decides how a battery-backed static memory may be used. It outputs four control flags: one that allows access, one that blocks writes, one that puts the data drivers into high impedance, and one that moves the array supply from the main rail to the backup cell. It also gates the host's read and write requests, so that no access reaches the array while protection is active.

The supply range is split into three ordered regions. In the full-operation region, reads and writes are allowed. In the protected region, writes are blocked, the data outputs float and bus requests are ignored. In the battery region, the array is fed from the backup cell. After reset the block is protected and the cell is isolated. It reaches full operation only after a qualified rise, and only then can the cell ever be switched in.

Leaving full operation takes effect on a single sample at the next clock edge. Every other change needs a run of agreeing valid samples. The full-entry threshold and both battery thresholds carry a hysteresis band set at run time.

Top module: `smon_wp_seq`

## Requirements
- R1: During and right after reset the outputs are access_en=0, write_inhibit=1, dq_tristate=1, backup_sel=0, and the block is in the isolated protected state.
- R2: From the isolated or protected state, the block enters full operation only after QUAL_N consecutive valid samples with sample_mv > FULL_MV + hyst_mv. Full operation means access_en=1, write_inhibit=0, dq_tristate=0, backup_sel=0.
- R3: In full operation, a single valid sample with sample_mv <= TRIP_MV moves the block to the protected state at that clock edge. The protected state means access_en=0, write_inhibit=1, dq_tristate=1, backup_sel=0.
- R4: wr_go equals wr_req and rd_go equals rd_req while access_en=1. Both are 0 in every other state, whatever the requests are, so a write in progress is cut off at the protecting edge.
- R5: From the protected state, QUAL_N consecutive valid samples with sample_mv < BATT_MV - hyst_mv select the backup cell. The battery state means backup_sel=1, access_en=0, write_inhibit=1, dq_tristate=1.
- R6: From the battery state, QUAL_N consecutive valid samples with sample_mv > BATT_MV + hyst_mv return the block to the protected state. Samples at or below BATT_MV + hyst_mv keep the backup cell selected.
- R7: Before the first entry into full operation, no sample level sets backup_sel.
- R8: A valid sample whose target is the current state, or a different state from the pending one, restarts the qualification count. A cycle with sample_valid=0 neither counts nor restarts, and it changes no output.
- R9: From the battery state, QUAL_N consecutive valid samples above FULL_MV + hyst_mv go straight to full operation, with backup_sel back at 0.
- R10: In the protected state, valid samples in the range TRIP_MV < sample_mv <= FULL_MV + hyst_mv keep the block protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | A new supply sample is present |
| sample_mv | input | SAMPLE_W | Supply sample in millivolts |
| hyst_mv | input | HYST_W | Hysteresis band in millivolts |
| wr_req | input | 1 | Host write request |
| rd_req | input | 1 | Host read request |
| access_en | output | 1 | Memory access allowed |
| write_inhibit | output | 1 | Writes blocked |
| dq_tristate | output | 1 | Data drivers in high impedance |
| backup_sel | output | 1 | Array fed from backup cell |
| wr_go | output | 1 | Gated write request |
| rd_go | output | 1 | Gated read request |

## Verification
The bench builds the block with QUAL_N=3 and the default thresholds of 4500, 4250 and 3000 mV. With a run length of three, interrupted runs, invalid gaps and completed runs all fit into short directed sequences. The bench changes hyst_mv between 0, 20 and 100 while it runs. This places samples on both sides of each widened band, including values that sit exactly on a threshold. Random runs of held levels, which dwell around every boundary, reach the transitions from battery straight to full operation and the trips that cut off a write.

// File: rtl/smon_pkg.sv
package smon_pkg;

   typedef enum logic [1:0] {
      SM_ISOLATED = 2'd0,
      SM_FULL     = 2'd1,
      SM_GUARD    = 2'd2,
      SM_BACKUP   = 2'd3
   } smon_state_e;

   typedef struct packed {
      logic access_en;
      logic write_inhibit;
      logic dq_tristate;
      logic backup_sel;
   } smon_ctl_t;

endpackage

// File: rtl/smon_classify.sv
module smon_classify
   import smon_pkg::*;
#(
   parameter int SAMPLE_W = 13,
   parameter int HYST_W   = 8,
   parameter int FULL_MV  = 4500,
   parameter int TRIP_MV  = 4250,
   parameter int BATT_MV  = 3000
) (
   input  smon_state_e          state,
   input  logic [SAMPLE_W-1:0]  sample_mv,
   input  logic [HYST_W-1:0]    hyst_mv,
   output smon_state_e          target,
   output logic                 trip_now
);
   localparam int CW = SAMPLE_W + 1;
   localparam logic [CW-1:0] FULL_C = CW'(FULL_MV);
   localparam logic [CW-1:0] TRIP_C = CW'(TRIP_MV);
   localparam logic [CW-1:0] BATT_C = CW'(BATT_MV);

   logic [CW-1:0] s_ext;
   logic [CW-1:0] h_ext;
   logic [CW-1:0] full_rise_thr;
   logic [CW-1:0] batt_fall_thr;
   logic [CW-1:0] batt_rise_thr;
   logic          above_full;
   logic          below_batt;

   assign s_ext         = {1'b0, sample_mv};
   assign h_ext         = CW'(hyst_mv);
   assign full_rise_thr = FULL_C + h_ext;
   assign batt_fall_thr = BATT_C - h_ext;
   assign batt_rise_thr = BATT_C + h_ext;

   assign trip_now   = (state == SM_FULL) && (s_ext <= TRIP_C);
   assign above_full = (state == SM_FULL) ? (s_ext > TRIP_C) : (s_ext > full_rise_thr);
   assign below_batt = (state == SM_BACKUP) ? (s_ext <= batt_rise_thr) : (s_ext < batt_fall_thr);

   always_comb begin
      if (above_full)                 target = SM_FULL;
      else if (state == SM_ISOLATED)  target = SM_ISOLATED;
      else if (below_batt)            target = SM_BACKUP;
      else                            target = SM_GUARD;
   end

endmodule

// File: rtl/smon_track.sv
module smon_track
   import smon_pkg::*;
#(
   parameter int QUAL_N = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sample_valid,
   input  smon_state_e target,
   input  logic        trip_now,
   output smon_state_e state
);
   generate
      if (QUAL_N == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            state <= SM_ISOLATED;
            else if (sample_valid) state <= trip_now ? SM_GUARD : target;
         end
      end else begin : g_counted
         localparam int CNT_W = $clog2(QUAL_N + 1);
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_N);

         logic [CNT_W-1:0] run_cnt;
         logic [CNT_W-1:0] run_nxt;
         smon_state_e      pend;

         assign run_nxt = (run_cnt != '0 && target == pend) ? run_cnt + 1'b1 : CNT_W'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state   <= SM_ISOLATED;
               pend    <= SM_ISOLATED;
               run_cnt <= '0;
            end else if (sample_valid) begin
               if (trip_now) begin
                  state   <= SM_GUARD;
                  run_cnt <= '0;
               end else if (target == state) begin
                  run_cnt <= '0;
               end else if (run_nxt == LIMIT) begin
                  state   <= target;
                  run_cnt <= '0;
               end else begin
                  pend    <= target;
                  run_cnt <= run_nxt;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/smon_ctl_map.sv
module smon_ctl_map
   import smon_pkg::*;
(
   input  smon_state_e state,
   output smon_ctl_t   ctl
);
   always_comb begin
      ctl = '{access_en: 1'b0, write_inhibit: 1'b1, dq_tristate: 1'b1, backup_sel: 1'b0};
      case (state)
         SM_FULL:   ctl = '{access_en: 1'b1, write_inhibit: 1'b0, dq_tristate: 1'b0, backup_sel: 1'b0};
         SM_BACKUP: ctl.backup_sel = 1'b1;
         default:   ;
      endcase
   end
endmodule

// File: rtl/smon_wp_seq.sv
module smon_wp_seq
   import smon_pkg::*;
#(
   parameter int SAMPLE_W = 13,
   parameter int HYST_W   = 8,
   parameter int FULL_MV  = 4500,
   parameter int TRIP_MV  = 4250,
   parameter int BATT_MV  = 3000,
   parameter int QUAL_N   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_valid,
   input  logic [SAMPLE_W-1:0] sample_mv,
   input  logic [HYST_W-1:0]   hyst_mv,
   input  logic                wr_req,
   input  logic                rd_req,
   output logic                access_en,
   output logic                write_inhibit,
   output logic                dq_tristate,
   output logic                backup_sel,
   output logic                wr_go,
   output logic                rd_go
);
   localparam int HYST_MAX = (1 << HYST_W) - 1;

   generate
      if (QUAL_N < 1) begin : g_bad_qual
         $error("QUAL_N must be at least 1");
      end
      if (TRIP_MV >= FULL_MV) begin : g_bad_trip
         $error("TRIP_MV must lie below FULL_MV");
      end
      if (BATT_MV + HYST_MAX >= TRIP_MV) begin : g_bad_batt
         $error("battery band must stay below TRIP_MV");
      end
      if (BATT_MV <= HYST_MAX) begin : g_bad_floor
         $error("BATT_MV must exceed the largest hysteresis");
      end
      if (FULL_MV + HYST_MAX >= (1 << SAMPLE_W)) begin : g_bad_width
         $error("SAMPLE_W too narrow for FULL_MV plus hysteresis");
      end
   endgenerate

   smon_state_e state;
   smon_state_e target;
   logic        trip_now;
   smon_ctl_t   ctl;

   smon_classify #(
      .SAMPLE_W(SAMPLE_W), .HYST_W(HYST_W),
      .FULL_MV(FULL_MV), .TRIP_MV(TRIP_MV), .BATT_MV(BATT_MV)
   ) u_classify (
      .state(state), .sample_mv(sample_mv), .hyst_mv(hyst_mv),
      .target(target), .trip_now(trip_now)
   );

   smon_track #(.QUAL_N(QUAL_N)) u_track (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .target(target), .trip_now(trip_now), .state(state)
   );

   smon_ctl_map u_map (.state(state), .ctl(ctl));

   assign access_en     = ctl.access_en;
   assign write_inhibit = ctl.write_inhibit;
   assign dq_tristate   = ctl.dq_tristate;
   assign backup_sel    = ctl.backup_sel;
   assign wr_go         = wr_req & ctl.access_en;
   assign rd_go         = rd_req & ctl.access_en;

endmodule

// File: rtl/smon_wp_seq_chk.sv
module smon_wp_seq_chk #(
   parameter int SAMPLE_W = 13,
   parameter int TRIP_MV  = 4250
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_valid,
   input logic [SAMPLE_W-1:0] sample_mv,
   input logic                wr_req,
   input logic                rd_req,
   input logic                access_en,
   input logic                write_inhibit,
   input logic                dq_tristate,
   input logic                backup_sel,
   input logic                wr_go,
   input logic                rd_go
);
   logic seen_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_full <= 1'b0;
      else if (access_en) seen_full <= 1'b1;
   end

   assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (write_inhibit && dq_tristate && !access_en && !backup_sel));

   assert_trip_next_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (access_en && sample_valid && ({1'b0, sample_mv} <= (SAMPLE_W+1)'(TRIP_MV)))
      |=> (!access_en && write_inhibit && dq_tristate));

   assert_gated_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !access_en |-> (!wr_go && !rd_go));

   assert_pass_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      access_en |-> (wr_go == wr_req && rd_go == rd_req));

   assert_backup_protected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      backup_sel |-> (write_inhibit && dq_tristate && !access_en));

   assert_isolated_cell_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_full |-> !backup_sel);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> ($stable(access_en) && $stable(backup_sel)));

   assert_backup_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(backup_sel) |-> $past(!access_en));

endmodule

bind smon_wp_seq smon_wp_seq_chk #(.SAMPLE_W(SAMPLE_W), .TRIP_MV(TRIP_MV)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_mv(sample_mv),
   .wr_req(wr_req), .rd_req(rd_req), .access_en(access_en),
   .write_inhibit(write_inhibit), .dq_tristate(dq_tristate),
   .backup_sel(backup_sel), .wr_go(wr_go), .rd_go(rd_go)
);

// File: tb/smon_wp_seq_bench.sv
module smon_wp_seq_bench;
   localparam int CLK_NS   = 10;
   localparam int SAMPLE_W = 13;
   localparam int HYST_W   = 8;
   localparam int FULL_MV  = 4500;
   localparam int TRIP_MV  = 4250;
   localparam int BATT_MV  = 3000;
   localparam int QUAL_N   = 3;

   localparam int ST_ISO = 0, ST_FULL = 1, ST_GUARD = 2, ST_BACK = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_valid = 1'b0;
   logic [SAMPLE_W-1:0] sample_mv = '0;
   logic [HYST_W-1:0] hyst_mv = 8'd20;
   logic wr_req = 1'b0, rd_req = 1'b0;
   logic access_en, write_inhibit, dq_tristate, backup_sel, wr_go, rd_go;

   int n_checks = 0;
   int n_fail   = 0;
   int m_state  = ST_ISO;
   int m_pend   = ST_ISO;
   int m_cnt    = 0;

   always #(CLK_NS/2) clk = ~clk;

   smon_wp_seq #(
      .SAMPLE_W(SAMPLE_W), .HYST_W(HYST_W), .FULL_MV(FULL_MV),
      .TRIP_MV(TRIP_MV), .BATT_MV(BATT_MV), .QUAL_N(QUAL_N)
   ) u_smon_wp_seq (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_mv(sample_mv),
      .hyst_mv(hyst_mv), .wr_req(wr_req), .rd_req(rd_req), .access_en(access_en),
      .write_inhibit(write_inhibit), .dq_tristate(dq_tristate),
      .backup_sel(backup_sel), .wr_go(wr_go), .rd_go(rd_go)
   );

   function automatic int want_state(int cur, int mv, int h);
      bit up, low;
      up  = (cur == ST_FULL) ? (mv > TRIP_MV) : (mv > FULL_MV + h);
      low = (cur == ST_BACK) ? (mv <= BATT_MV + h) : (mv < BATT_MV - h);
      if (up)            return ST_FULL;
      if (cur == ST_ISO) return ST_ISO;
      if (low)           return ST_BACK;
      return ST_GUARD;
   endfunction

   function automatic logic [5:0] expect_outs(int st, logic wr, logic rd);
      logic full;
      full = (st == ST_FULL);
      return {full, !full, !full, st == ST_BACK, wr & full, rd & full};
   endfunction

   task automatic model_edge();
      int tg;
      if (!sample_valid) return;
      if (m_state == ST_FULL && int'(sample_mv) <= TRIP_MV) begin
         m_state = ST_GUARD; m_cnt = 0; return;
      end
      tg = want_state(m_state, int'(sample_mv), int'(hyst_mv));
      if (tg == m_state) begin m_cnt = 0; return; end
      if (m_cnt > 0 && tg == m_pend) m_cnt++;
      else begin m_cnt = 1; m_pend = tg; end
      if (m_cnt == QUAL_N) begin m_state = tg; m_cnt = 0; end
   endtask

   task automatic check_outs(string tag);
      logic [5:0] got, exp;
      got = {access_en, write_inhibit, dq_tristate, backup_sel, wr_go, rd_go};
      exp = expect_outs(m_state, wr_req, rd_req);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (acc,inh,tri,bak,wgo,rgo)", tag, got, exp);
      end
   endtask

   task automatic step(logic v, int mv, logic wr, logic rd, string tag);
      sample_valid = v;
      sample_mv    = SAMPLE_W'(mv);
      wr_req       = wr;
      rd_req       = rd;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_outs(tag);
   endtask

   task automatic hold(int reps, int mv, string tag);
      for (int i = 0; i < reps; i++) step(1'b1, mv, 1'b0, 1'b0, tag);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int lvl [12] = '{2700, 2950, 2980, 3000, 3020, 3300, 4200, 4250, 4260, 4520, 4600, 5000};
      void'($urandom(32'd4242));
      @(negedge clk);
      check_outs("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1 after reset");

      hold(5, 2000, "R7 low supply before first power");
      hold(2, 4600, "R2 rise not yet qualified");
      hold(1, 4600, "R2 qualified rise");
      step(1'b1, 4600, 1'b1, 1'b1, "R4 requests pass in full");
      step(1'b1, 4250, 1'b1, 1'b1, "R3 trip on one sample aborts write");
      step(1'b0, 4250, 1'b1, 1'b0, "R4 requests ignored when protected");
      hold(4, 4520, "R10 inside band stays protected");
      hold(3, 2970, "R5 drop to backup cell");
      hold(4, 3020, "R6 inside band keeps backup");
      hold(3, 3030, "R6 rise leaves backup");
      hold(2, 2970, "R8 partial run");
      step(1'b0, 2000, 1'b0, 1'b0, "R8 invalid sample ignored");
      step(1'b0, 2000, 1'b0, 1'b0, "R8 invalid sample ignored");
      hold(1, 2970, "R8 run spans invalid gap");
      hold(2, 3030, "R8 rise partial");
      hold(1, 3000, "R8 same region restarts");
      hold(2, 3030, "R8 restarted run not done");
      hold(1, 3030, "R6 restarted run completes");
      hold(3, 2900, "R5 back to cell");
      hold(2, 4600, "R9 partial");
      hold(1, 4600, "R9 battery to full");
      hyst_mv = 8'd100;
      hold(1, 4250, "R3 trip");
      hold(3, 4600, "R10 hysteresis 100 blocks 4600");
      hold(3, 4601, "R2 above widened band");
      hyst_mv = 8'd0;
      hold(1, 4251, "R3 just above trip keeps full");

      for (int r = 0; r < 1500; r++) begin
         int mv, len;
         if (($urandom % 10) == 0) hyst_mv = HYST_W'((($urandom % 3) == 0) ? 0 : (($urandom % 2) ? 20 : 100));
         mv  = lvl[$urandom % 12] + int'($urandom % 41) - 20;
         len = 1 + int'($urandom % 5);
         for (int k = 0; k < len; k++)
            step(($urandom % 5) != 0, mv, 1'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R9 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule